// File: doc/BRIEF.md
# Region Access Guard

This block checks every memory access made by a processor core against a set of programmable protection regions. Each access presents an address, an access kind (instruction fetch, load or store) and a privilege flag. The guard finds the enabled region that covers the address and decodes that region's permission code for the access. Where regions overlap, the highest-numbered one decides. When no region covers the address, a background rule decides. The verdict is registered: one cycle after the request it gives allow or fault, together with a flag that marks instruction fetches, so that fault-status logic can classify the violation.

Every region has its own parallel configuration inputs: an enable bit, a base address, a 5-bit size code, an 8-bit subregion-disable mask, a 3-bit permission code and an execute-never bit. Three global controls complete the configuration. One switches the unit on. One lets privileged accesses use the background region. One keeps the checks active while the core runs its fault or non-maskable interrupt handlers. A register file that holds these values sits outside the block, as do memory-type attributes and exception delivery.

Top module: `regionGuard`

## Requirements
- R1: A request accepted on a rising edge produces `rspValid` high after that edge, for exactly one cycle. `rspValid` stays low on cycles that follow no request, and `rspFault` is never high while `rspValid` is low. Reset clears `rspValid`, `rspFault` and `rspIsFetch`.
- R2: When `unitEnable` is low, every access is allowed, whatever the privilege or region settings.
- R3: Size code s makes a region cover 2^(s+1) bytes. The low s+1 bits of its base are ignored, so a match compares only the bits above them. Codes below 4 act as code 4 (32 bytes), and code 31 covers the whole 32-bit space.
- R4: When several enabled regions cover an address, the one with the highest index supplies the permission code and the execute-never bit. A region whose enable bit is low covers no address.
- R5: For size codes of 7 or more (256 bytes and up), address bits [s-2 +: 3] select one of eight subregions. Setting bit k of the region's disable mask removes subregion k from that region, and lower regions or the background rule then decide the access.
- R6: For size codes below 7, the subregion-disable mask has no effect.
- R7: Permission codes (P = privileged, U = unprivileged; a read is a load or a fetch, a write is a store, reqKind 2'b11 counts as a store): 000 and 100 deny all; 001 gives P read/write and no U access; 010 gives P read/write and U read-only; 011 gives read/write to both; 101 gives P read-only and no U access; 110 and 111 give read-only to both.
- R8: When the winning region's execute-never bit is set, an instruction fetch (reqKind 2'b00) faults, whatever its permission code allows. Loads and stores are unaffected.
- R9: With the unit enabled and no region covering the address, a privileged access is allowed only if `bgEnable` is high. An unprivileged access faults.
- R10: With the unit enabled, `inHandler` high and `handlerEnforce` low, the access is allowed without any check. With `handlerEnforce` high, handler accesses are checked as usual.
- R11: `rspIsFetch` is high with a response exactly when the request was an instruction fetch (reqKind 2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reqValid | input | 1 | Access request present this cycle |
| reqAddr | input | ADDR_W | Access address |
| reqKind | input | 2 | 00 fetch, 01 load, 10/11 store |
| reqPriv | input | 1 | Access is privileged |
| inHandler | input | 1 | Core is running a fault or NMI handler |
| unitEnable | input | 1 | Global enable for checking |
| bgEnable | input | 1 | Background region for privileged accesses |
| handlerEnforce | input | 1 | Keep checks active inside handlers |
| regEnable | input | NUM_REGIONS | Per-region enable |
| regBase | input | NUM_REGIONS*ADDR_W | Per-region base address, region i at [i*ADDR_W +: ADDR_W] |
| regSize | input | NUM_REGIONS*5 | Per-region size code |
| regSubDis | input | NUM_REGIONS*8 | Per-region subregion-disable mask |
| regPerm | input | NUM_REGIONS*3 | Per-region permission code |
| regXn | input | NUM_REGIONS | Per-region execute-never |
| rspValid | output | 1 | Verdict present |
| rspFault | output | 1 | Access violates protection |
| rspIsFetch | output | 1 | Verdict belongs to an instruction fetch |

## Verification
Every verdict is due on the first rising edge after the request cycle: one register stage sits between the request inputs and `rspValid`, `rspFault` and `rspIsFetch`. The driver applies each request and configuration change on a falling edge and pushes the expected fault and fetch flags into a queue. The monitor samples the outputs on the next falling edge, half a cycle after the register loads. It pops one expectation per valid response, and a response that arrives with an empty queue counts as a fault against R1. After the last request, an empty queue shows that no response went missing.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH  = 2'b00,
    KIND_LOAD   = 2'b01,
    KIND_STORE  = 2'b10,
    KIND_STORE2 = 2'b11
  } accessKind_t;

  // winning region after overlap resolution
  typedef struct packed {
    logic       hit;
    logic [2:0] perm;
    logic       xn;
  } regionPick_t;

  // strobes from the decision logic to the output register
  typedef struct packed {
    logic capture;
    logic fault;
    logic isFetch;
  } guardStrobe_t;

endpackage

// File: rtl/guardMatch.sv
module guardMatch
  import guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [NUM_REGIONS-1:0]        regEnable,
  input  logic [NUM_REGIONS*ADDR_W-1:0] regBase,
  input  logic [NUM_REGIONS*5-1:0]      regSize,
  input  logic [NUM_REGIONS*8-1:0]      regSubDis,
  input  logic [NUM_REGIONS*3-1:0]      regPerm,
  input  logic [NUM_REGIONS-1:0]        regXn,
  input  guardStrobe_t                  strobe,
  output regionPick_t                   pick,
  output logic                          rspValid,
  output logic                          rspFault,
  output logic                          rspIsFetch
);
  localparam int SIZE_W       = 5;
  localparam int SUB_N        = 8;
  localparam int SUB_IDX_W    = $clog2(SUB_N);
  localparam int PERM_W       = 3;
  localparam int MIN_CODE     = 4;   // 32 bytes
  localparam int SUB_MIN_CODE = 7;   // 256 bytes

  logic [NUM_REGIONS-1:0] hitVec;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegion
    logic [SIZE_W-1:0]    rawCode;
    logic [SIZE_W-1:0]    effCode;
    logic [ADDR_W:0]      span;
    logic [ADDR_W-1:0]    keepMask;
    logic [ADDR_W-1:0]    baseVal;
    logic [SUB_N-1:0]     subMask;
    logic [SUB_IDX_W-1:0] subIdx;
    logic                 upperEq;
    logic                 subOff;

    always_comb begin
      rawCode  = regSize[g*SIZE_W +: SIZE_W];
      effCode  = (rawCode < SIZE_W'(MIN_CODE)) ? SIZE_W'(MIN_CODE) : rawCode;
      span     = (ADDR_W+1)'(1) << (int'(effCode) + 1);
      keepMask = ~ADDR_W'(span - (ADDR_W+1)'(1));
      baseVal  = regBase[g*ADDR_W +: ADDR_W];
      subMask  = regSubDis[g*SUB_N +: SUB_N];
      upperEq  = ((reqAddr ^ baseVal) & keepMask) == '0;
      subIdx   = SUB_IDX_W'(reqAddr >> (int'(effCode) - 2));
      subOff   = (effCode >= SIZE_W'(SUB_MIN_CODE)) && subMask[subIdx];
      hitVec[g] = regEnable[g] && upperEq && !subOff;
    end
  end

  // ascending scan: the last (highest) hit overwrites earlier ones
  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hitVec[i]) begin
        pick.hit  = 1'b1;
        pick.perm = regPerm[i*PERM_W +: PERM_W];
        pick.xn   = regXn[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid   <= 1'b0;
      rspFault   <= 1'b0;
      rspIsFetch <= 1'b0;
    end else begin
      rspValid   <= strobe.capture;
      rspFault   <= strobe.capture & strobe.fault;
      rspIsFetch <= strobe.capture & strobe.isFetch;
    end
  end

endmodule

// File: rtl/guardDecide.sv
module guardDecide
  import guard_pkg::*;
(
  input  logic         reqValid,
  input  logic [1:0]   reqKind,
  input  logic         reqPriv,
  input  logic         inHandler,
  input  logic         unitEnable,
  input  logic         bgEnable,
  input  logic         handlerEnforce,
  input  regionPick_t  pick,
  output guardStrobe_t strobe
);
  accessKind_t kind;
  logic isFetch, isWrite;
  logic privRd, privWr, userRd, userWr;
  logic rdOk, wrOk, permOk, allow;

  always_comb begin
    kind    = accessKind_t'(reqKind);
    isFetch = (kind == KIND_FETCH);
    isWrite = (kind == KIND_STORE) || (kind == KIND_STORE2);

    {privRd, privWr, userRd, userWr} = 4'b0000;
    unique case (pick.perm)
      3'b001:          {privRd, privWr, userRd, userWr} = 4'b1100;
      3'b010:          {privRd, privWr, userRd, userWr} = 4'b1110;
      3'b011:          {privRd, privWr, userRd, userWr} = 4'b1111;
      3'b101:          {privRd, privWr, userRd, userWr} = 4'b1000;
      3'b110, 3'b111:  {privRd, privWr, userRd, userWr} = 4'b1010;
      default:         {privRd, privWr, userRd, userWr} = 4'b0000;
    endcase

    rdOk   = reqPriv ? privRd : userRd;
    wrOk   = reqPriv ? privWr : userWr;
    permOk = isWrite ? wrOk : rdOk;

    if (!unitEnable || (inHandler && !handlerEnforce)) begin
      allow = 1'b1;
    end else if (pick.hit) begin
      allow = permOk && !(isFetch && pick.xn);
    end else begin
      allow = reqPriv && bgEnable;
    end

    strobe.capture = reqValid;
    strobe.fault   = !allow;
    strobe.isFetch = isFetch;
  end

endmodule

// File: rtl/regionGuard.sv
module regionGuard
  import guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reqValid,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [1:0]                    reqKind,
  input  logic                          reqPriv,
  input  logic                          inHandler,
  input  logic                          unitEnable,
  input  logic                          bgEnable,
  input  logic                          handlerEnforce,
  input  logic [NUM_REGIONS-1:0]        regEnable,
  input  logic [NUM_REGIONS*ADDR_W-1:0] regBase,
  input  logic [NUM_REGIONS*5-1:0]      regSize,
  input  logic [NUM_REGIONS*8-1:0]      regSubDis,
  input  logic [NUM_REGIONS*3-1:0]      regPerm,
  input  logic [NUM_REGIONS-1:0]        regXn,
  output logic                          rspValid,
  output logic                          rspFault,
  output logic                          rspIsFetch
);
  regionPick_t  pick;
  guardStrobe_t strobe;

  guardMatch #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) uMatch (
    .clk(clk), .rst_n(rst_n), .reqAddr(reqAddr),
    .regEnable(regEnable), .regBase(regBase), .regSize(regSize),
    .regSubDis(regSubDis), .regPerm(regPerm), .regXn(regXn),
    .strobe(strobe), .pick(pick),
    .rspValid(rspValid), .rspFault(rspFault), .rspIsFetch(rspIsFetch)
  );

  guardDecide uDecide (
    .reqValid(reqValid), .reqKind(reqKind), .reqPriv(reqPriv),
    .inHandler(inHandler), .unitEnable(unitEnable), .bgEnable(bgEnable),
    .handlerEnforce(handlerEnforce), .pick(pick), .strobe(strobe)
  );

endmodule

// File: rtl/guardChecker.sv
module guardChecker (
  input logic       clk,
  input logic       rst_n,
  input logic       reqValid,
  input logic [1:0] reqKind,
  input logic       inHandler,
  input logic       unitEnable,
  input logic       handlerEnforce,
  input logic       rspValid,
  input logic       rspFault,
  input logic       rspIsFetch
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid); // R1
  AST_FAULT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rspFault |-> rspValid); // R1
  AST_DISABLED_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !unitEnable) |=> !rspFault); // R2
  AST_HANDLER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && unitEnable && inHandler && !handlerEnforce) |=> !rspFault); // R10
  AST_FETCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> (rspIsFetch == ($past(reqKind) == 2'b00))); // R11
endmodule

bind regionGuard guardChecker uChecker (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqKind(reqKind),
  .inHandler(inHandler), .unitEnable(unitEnable),
  .handlerEnforce(handlerEnforce), .rspValid(rspValid),
  .rspFault(rspFault), .rspIsFetch(rspIsFetch)
);

// File: tb/tb_regionGuard.sv
module tb_regionGuard;
  localparam int N = 8;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0] reqKind = 2'b01;
  logic reqPriv = 1'b0;
  logic inHandler = 1'b0;
  logic unitEnable = 1'b0;
  logic bgEnable = 1'b0;
  logic handlerEnforce = 1'b0;
  logic [N-1:0] regEnable = '0;
  logic [N*AW-1:0] regBase = '0;
  logic [N*5-1:0] regSize = '0;
  logic [N*8-1:0] regSubDis = '0;
  logic [N*3-1:0] regPerm = '0;
  logic [N-1:0] regXn = '0;
  logic rspValid, rspFault, rspIsFetch;

  int checks = 0;
  int fails = 0;
  bit expFaultQ[$];
  bit expFetchQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  regionGuard #(.NUM_REGIONS(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqPriv(reqPriv), .inHandler(inHandler),
    .unitEnable(unitEnable), .bgEnable(bgEnable), .handlerEnforce(handlerEnforce),
    .regEnable(regEnable), .regBase(regBase), .regSize(regSize),
    .regSubDis(regSubDis), .regPerm(regPerm), .regXn(regXn),
    .rspValid(rspValid), .rspFault(rspFault), .rspIsFetch(rspIsFetch)
  );

  task automatic setRegion(input int idx, input bit en, input logic [AW-1:0] base,
                           input logic [4:0] code, input logic [7:0] subDis,
                           input logic [2:0] perm, input bit xn);
    regEnable[idx]        = en;
    regBase[idx*AW +: AW] = base;
    regSize[idx*5 +: 5]   = code;
    regSubDis[idx*8 +: 8] = subDis;
    regPerm[idx*3 +: 3]   = perm;
    regXn[idx]            = xn;
  endtask

  task automatic clearRegions();
    for (int i = 0; i < N; i++) setRegion(i, 1'b0, '0, 5'd0, 8'h00, 3'b000, 1'b0);
  endtask

  // called at a falling edge; result due at the next falling edge
  task automatic issue(input logic [AW-1:0] addr, input logic [1:0] kind,
                       input bit priv, input bit expFault, input string tag);
    reqAddr  = addr;
    reqKind  = kind;
    reqPriv  = priv;
    reqValid = 1'b1;
    expFaultQ.push_back(expFault);
    expFetchQ.push_back(kind == 2'b00);
    tagQ.push_back(tag);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rspValid) begin
        if (expFaultQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R1 unexpected response: got rspValid=1 expected 0");
        end else begin
          bit ef, ep;
          string tg;
          ef = expFaultQ.pop_front();
          ep = expFetchQ.pop_front();
          tg = tagQ.pop_front();
          checks++;
          if (rspFault !== ef) begin
            fails++;
            $display("FAIL %s fault: got %0b expected %0b", tg, rspFault, ef);
          end
          checks++;
          if (rspIsFetch !== ep) begin
            fails++;
            $display("FAIL R11 (%s) fetch flag: got %0b expected %0b", tg, rspIsFetch, ep);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || rspFault !== 1'b0 || rspIsFetch !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got %0b%0b%0b expected 000", rspValid, rspFault, rspIsFetch);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2: disabled unit allows everything
    issue(32'h5000_0000, 2'b10, 1'b0, 1'b0, "R2");
    issue(32'h5000_0000, 2'b00, 1'b0, 1'b0, "R2");

    // R9: background rule
    unitEnable = 1'b1;
    issue(32'h5000_0000, 2'b01, 1'b1, 1'b1, "R9");
    bgEnable = 1'b1;
    issue(32'h5000_0000, 2'b01, 1'b1, 1'b0, "R9");
    issue(32'h5000_0000, 2'b01, 1'b0, 1'b1, "R9");

    // R3/R4: 1 KB region 0 full access, 256 B region 3 no access on top
    setRegion(0, 1'b1, 32'h2000_0000, 5'd9, 8'h00, 3'b011, 1'b0);
    setRegion(3, 1'b1, 32'h2000_0000, 5'd7, 8'h00, 3'b000, 1'b0);
    issue(32'h2000_0080, 2'b01, 1'b0, 1'b1, "R4");
    issue(32'h2000_0100, 2'b01, 1'b0, 1'b0, "R3");
    issue(32'h2000_03FC, 2'b10, 1'b0, 1'b0, "R3");
    issue(32'h2000_0400, 2'b10, 1'b0, 1'b1, "R3");
    issue(32'h1FFF_FFFC, 2'b10, 1'b0, 1'b1, "R3");
    setRegion(3, 1'b0, 32'h2000_0000, 5'd7, 8'h00, 3'b000, 1'b0);
    issue(32'h2000_0080, 2'b01, 1'b0, 1'b0, "R4");
    setRegion(3, 1'b1, 32'h2000_0000, 5'd7, 8'h00, 3'b000, 1'b0);

    // R5: subregions
    setRegion(3, 1'b1, 32'h2000_0000, 5'd7, 8'b0000_0100, 3'b000, 1'b0);
    issue(32'h2000_0040, 2'b01, 1'b0, 1'b0, "R5");
    issue(32'h2000_0060, 2'b01, 1'b0, 1'b1, "R5");
    setRegion(0, 1'b1, 32'h2000_0000, 5'd9, 8'b1000_0000, 3'b011, 1'b0);
    issue(32'h2000_0380, 2'b01, 1'b1, 1'b0, "R5");
    issue(32'h2000_0380, 2'b01, 1'b0, 1'b1, "R5");
    issue(32'h2000_0300, 2'b01, 1'b0, 1'b0, "R5");

    // R6: small regions ignore subregion mask, R3 minimum size
    clearRegions();
    setRegion(1, 1'b1, 32'h3000_0040, 5'd2, 8'hFF, 3'b011, 1'b0);
    issue(32'h3000_005F, 2'b01, 1'b0, 1'b0, "R6");
    issue(32'h3000_0060, 2'b01, 1'b0, 1'b1, "R3");
    setRegion(1, 1'b1, 32'h3000_0000, 5'd6, 8'hFF, 3'b011, 1'b0);
    issue(32'h3000_007C, 2'b01, 1'b0, 1'b0, "R6");

    // R7: permission codes
    clearRegions();
    bgEnable = 1'b0;
    setRegion(4, 1'b1, 32'h4000_0000, 5'd11, 8'h00, 3'b001, 1'b0);
    issue(32'h4000_0010, 2'b10, 1'b1, 1'b0, "R7");
    issue(32'h4000_0010, 2'b01, 1'b0, 1'b1, "R7");
    setRegion(4, 1'b1, 32'h4000_0000, 5'd11, 8'h00, 3'b010, 1'b0);
    issue(32'h4000_0010, 2'b01, 1'b0, 1'b0, "R7");
    issue(32'h4000_0010, 2'b10, 1'b0, 1'b1, "R7");
    issue(32'h4000_0010, 2'b11, 1'b1, 1'b0, "R7");
    setRegion(4, 1'b1, 32'h4000_0000, 5'd11, 8'h00, 3'b101, 1'b0);
    issue(32'h4000_0010, 2'b01, 1'b1, 1'b0, "R7");
    issue(32'h4000_0010, 2'b10, 1'b1, 1'b1, "R7");
    issue(32'h4000_0010, 2'b01, 1'b0, 1'b1, "R7");
    setRegion(4, 1'b1, 32'h4000_0000, 5'd11, 8'h00, 3'b110, 1'b0);
    issue(32'h4000_0010, 2'b01, 1'b0, 1'b0, "R7");
    issue(32'h4000_0010, 2'b10, 1'b1, 1'b1, "R7");
    setRegion(4, 1'b1, 32'h4000_0000, 5'd11, 8'h00, 3'b100, 1'b0);
    issue(32'h4000_0010, 2'b01, 1'b1, 1'b1, "R7");
    setRegion(4, 1'b1, 32'h4000_0000, 5'd11, 8'h00, 3'b000, 1'b0);
    issue(32'h4000_0010, 2'b01, 1'b1, 1'b1, "R7");

    // R8 / R11: execute-never
    setRegion(4, 1'b1, 32'h4000_0000, 5'd11, 8'h00, 3'b011, 1'b1);
    issue(32'h4000_0020, 2'b00, 1'b1, 1'b1, "R8");
    issue(32'h4000_0020, 2'b01, 1'b1, 1'b0, "R8");
    setRegion(4, 1'b1, 32'h4000_0000, 5'd11, 8'h00, 3'b011, 1'b0);
    issue(32'h4000_0020, 2'b00, 1'b0, 1'b0, "R11");

    // R10: handler bypass
    clearRegions();
    inHandler = 1'b1;
    issue(32'h6000_0000, 2'b10, 1'b0, 1'b0, "R10");
    handlerEnforce = 1'b1;
    issue(32'h6000_0000, 2'b10, 1'b0, 1'b1, "R10");
    inHandler = 1'b0;
    handlerEnforce = 1'b0;

    // R3: full-space region
    setRegion(7, 1'b1, 32'h1234_5678, 5'd31, 8'h00, 3'b011, 1'b0);
    issue(32'hFFFF_FFF0, 2'b10, 1'b0, 1'b0, "R3");
    issue(32'h0000_0000, 2'b01, 1'b0, 1'b0, "R3");

    repeat (3) @(negedge clk);
    checks++;
    if (expFaultQ.size() != 0) begin
      fails++;
      $display("FAIL R1 missing responses: got %0d pending expected 0", expFaultQ.size());
    end
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule